// File: doc/BRIEF.md
# Serial Peripheral Port with Per-Word Request Pacing

This block is a four-wire synchronous serial port that runs either as the clock-generating controller or as the clocked target on the bus. It moves 24-bit words, most significant bit first, in clock mode 0. Data is sampled on the rising clock edge and changed on the falling edge. On the parallel side it has a transmit word register, a receive word register and a few status flags.

A fifth line, active low, paces the traffic one word at a time. As target, the port pulls this line low when it has fresh transmit data and an empty receive register. It releases the line on the first clock pulse of the word. As controller, the port watches the same line and starts a word only after the line has gone high since its last word and is low again.

The port also flags a bus error when its select input is pulled low while it is the controller. Until a mode is enabled, every pin it could drive stays released.

Top module: `spi_req_port`

## Requirements
- R1: While `cfgEnable` is low, including just after reset, all four output enables (`sckOe`, `mosiOe`, `misoOe`, `hreqOe`) are 0 and `hreqOut` is 1.
- R2: With `cfgEnable`=1 and `cfgMaster`=1, `sckOe`=1, `mosiOe`=1, `misoOe`=0 and `hreqOe`=0. With `cfgMaster`=0 and `ssN` low, `sckOe`=0, `mosiOe`=0, `misoOe`=1 and `hreqOe`=1.
- R3: A word is 24 bits, sent MSB first on `mosiOut` (controller) or `misoOut` (target). Bits are sampled on rising SCK and changed on falling SCK. The controller's SCK is low whenever no word is in progress.
- R4: As controller, each SCK half period lasts `clkDiv`+1 system clock cycles, so rising edges within a word are 2·(`clkDiv`+1) cycles apart.
- R5: As controller, a loaded word starts only while the synchronized `hreqIn` is low and after `hreqIn` has been seen high since the previous start. Otherwise SCK stays low.
- R6: As target, `hreqOut` goes low only when a transmit word has been loaded since the last word and the receive register is empty. It returns high on the first rising SCK edge of the word.
- R7: As target with `ssN` high, SCK edges are ignored: no bits are received, `rxFull` does not change, `hreqOut` stays as it was, and `misoOe`=0.
- R8: As controller, a low level on `ssN` sets `busError`. The flag stays set until `cfgEnable` is taken low.
- R9: `rxFull` rises when a complete word is received, and a one-cycle `rxRead` pulse clears it.
- R10: If a word completes while `rxFull`=1 and `rxRead` is not pulsed, `rxOverrun` is set and `rxData` keeps the older word. `rxRead` clears `rxOverrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Enables the port in the selected mode |
| cfgMaster | input | 1 | 1 = controller, 0 = target |
| clkDiv | input | 8 | Controller SCK half period minus one, in system cycles |
| txData | input | 24 | Word to transmit |
| txLoad | input | 1 | Strobe that writes `txData` into the transmit register |
| rxData | output | 24 | Last accepted received word |
| rxRead | input | 1 | Strobe that acknowledges `rxData` |
| rxFull | output | 1 | Received word waiting |
| rxOverrun | output | 1 | A word arrived while the previous one was unread |
| busError | output | 1 | Select seen low in controller mode |
| sckIn | input | 1 | Serial clock from the pin |
| sckOut | output | 1 | Generated serial clock |
| sckOe | output | 1 | Drive enable for the clock pin |
| mosiIn | input | 1 | Controller-to-target data from the pin |
| mosiOut | output | 1 | Controller-to-target data to the pin |
| mosiOe | output | 1 | Drive enable for the controller-to-target pin |
| misoIn | input | 1 | Target-to-controller data from the pin |
| misoOut | output | 1 | Target-to-controller data to the pin |
| misoOe | output | 1 | Drive enable for the target-to-controller pin |
| ssN | input | 1 | Active-low select |
| hreqIn | input | 1 | Request line from the pin (active low) |
| hreqOut | output | 1 | Request line to the pin (active low) |
| hreqOe | output | 1 | Drive enable for the request line |

## Verification
The embedded properties check rules that must hold on every cycle:
- the generated clock stays low while no word is active;
- a controller word begins only after a sampled low request that was re-armed;
- the target request falls only with room and fresh data;
- a deselected target never fills its receive register;
- a low select in controller mode sets the error flag;
- held receive data stays put until it is read.

The bench connects a controller instance to a target instance and sweeps dividers and data patterns. Those scenarios alone show the end-to-end word integrity, the MSB-first order on the wire, the measured clock period, the pull-up value seen when the target is deselected, and the exact hand-over moments of the request line.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadTx;     // copy holding register into shifter
    logic shiftTx;    // advance outgoing bit
    logic sampleBit;  // shift one incoming bit in
    logic capture;    // publish received word
  } dpCtrl_t;

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/spi_req_dp.sv
module spi_req_dp
  import spi_req_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              txLoad,
  input  logic [WORD_W-1:0] txData,
  input  logic              isMaster,
  input  logic              misoIn,
  input  logic              mosiSync,
  output logic [WORD_W-1:0] rxData,
  output logic              serOut
);

  logic [WORD_W-1:0] txHold;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;
  logic              inBit;

  // controller samples the returning line, target samples the synchronized input
  assign inBit  = isMaster ? misoIn : mosiSync;
  assign rxNext = ctl.sampleBit ? {rxShift[WORD_W-2:0], inBit} : rxShift;
  assign serOut = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (txLoad) txHold <= txData;
      if (ctl.loadTx) txShift <= txHold;
      else if (ctl.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
      rxShift <= rxNext;
      if (ctl.capture) rxData <= rxNext;
    end
  end

endmodule

// File: rtl/spi_req_ctrl.sv
module spi_req_ctrl
  import spi_req_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgMaster,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txLoad,
  input  logic             rxRead,
  input  logic             sckSync,
  input  logic             ssNSync,
  input  logic             hreqSync,
  output dpCtrl_t          ctl,
  output logic             sckGen,
  output logic             hreqAsserted,
  output logic             rxFull,
  output logic             rxOverrun,
  output logic             busError,
  output logic             isMaster,
  output logic             isSlave
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic             sckPrev;
  logic             busy;
  logic             armed;
  logic             txValid;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;

  logic slaveSel, sRise, sFall, sDone;
  logic slaveReady, mStart, tick, mRise, mFall, mDone;
  logic wordDone, accept;

  always_comb begin
    isMaster   = cfgEnable & cfgMaster;
    isSlave    = cfgEnable & ~cfgMaster;
    slaveSel   = isSlave & ~ssNSync;
    sRise      = slaveSel & sckSync & ~sckPrev;
    sFall      = slaveSel & ~sckSync & sckPrev;
    sDone      = sRise & (bitCnt == LAST_IDX);
    slaveReady = isSlave & ~hreqAsserted & (bitCnt == '0) & txValid & ~rxFull & ~sRise;
    mStart     = isMaster & ~busy & txValid & armed & ~hreqSync;
    tick       = isMaster & busy & (divCnt == clkDiv);
    mRise      = tick & ~sckGen;
    mFall      = tick & sckGen;
    mDone      = mFall & (bitCnt == FULL_CNT);
    wordDone   = mDone | sDone;
    accept     = wordDone & ~(rxFull & ~rxRead);
    ctl.loadTx    = slaveReady | mStart;
    ctl.shiftTx   = (sFall & (bitCnt != '0)) | (mFall & (bitCnt != FULL_CNT));
    ctl.sampleBit = sRise | mRise;
    ctl.capture   = accept;
  end

  // receive and transmit bookkeeping, independent of mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      txValid   <= 1'b0;
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      sckPrev <= sckSync;
      txValid <= (txValid & ~ctl.loadTx) | txLoad;
      if (accept) rxFull <= 1'b1;
      else if (rxRead) rxFull <= 1'b0;
      if (wordDone & rxFull & ~rxRead) rxOverrun <= 1'b1;
      else if (rxRead) rxOverrun <= 1'b0;
    end
  end

  // word sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      armed        <= 1'b0;
      bitCnt       <= '0;
      divCnt       <= '0;
      sckGen       <= 1'b0;
      hreqAsserted <= 1'b0;
      busError     <= 1'b0;
    end else if (!cfgEnable) begin
      busy         <= 1'b0;
      armed        <= 1'b0;
      bitCnt       <= '0;
      divCnt       <= '0;
      sckGen       <= 1'b0;
      hreqAsserted <= 1'b0;
      busError     <= 1'b0;
    end else if (isSlave) begin
      busy   <= 1'b0;
      sckGen <= 1'b0;
      divCnt <= '0;
      if (ssNSync) bitCnt <= '0;
      else if (sRise) bitCnt <= sDone ? '0 : bitCnt + CNT_W'(1);
      if (sRise) hreqAsserted <= 1'b0;
      else if (slaveReady) hreqAsserted <= 1'b1;
    end else begin
      hreqAsserted <= 1'b0;
      if (!ssNSync) busError <= 1'b1;
      if (hreqSync) armed <= 1'b1;
      if (mStart) begin
        busy   <= 1'b1;
        armed  <= 1'b0;
        divCnt <= '0;
        sckGen <= 1'b0;
        bitCnt <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          sckGen <= ~sckGen;
          if (mRise) bitCnt <= bitCnt + CNT_W'(1);
          if (mDone) begin
            busy   <= 1'b0;
            bitCnt <= '0;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !busy) |-> !sckGen); // R3

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!hreqSync && armed)); // R5

  AST_REQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hreqAsserted) |-> $past(txValid && !rxFull)); // R6

  AST_DESELECT_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (isSlave && ssNSync && !rxRead) |=> !$rose(rxFull)); // R7

  AST_BUS_ERROR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !ssNSync) |=> busError); // R8

endmodule

// File: rtl/spi_req_port.sv
module spi_req_port
  import spi_req_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [WORD_W-1:0] txData,
  input  logic              txLoad,
  output logic [WORD_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxFull,
  output logic              rxOverrun,
  output logic              busError,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN,
  input  logic              hreqIn,
  output logic              hreqOut,
  output logic              hreqOe
);

  dpCtrl_t ctl;
  logic    sckSync, ssNSync, mosiSync, hreqSync;
  logic    sckGen, hreqAsserted, isMaster, isSlave, serOut;

  // idle levels: clock low, select high, data low, request high
  spi_req_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0101)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sckIn, ssN, mosiIn, hreqIn}),
    .syncOut({sckSync, ssNSync, mosiSync, hreqSync})
  );

  spi_req_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .clkDiv(clkDiv), .txLoad(txLoad), .rxRead(rxRead),
    .sckSync(sckSync), .ssNSync(ssNSync), .hreqSync(hreqSync),
    .ctl(ctl), .sckGen(sckGen), .hreqAsserted(hreqAsserted),
    .rxFull(rxFull), .rxOverrun(rxOverrun), .busError(busError),
    .isMaster(isMaster), .isSlave(isSlave)
  );

  spi_req_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txLoad(txLoad), .txData(txData),
    .isMaster(isMaster), .misoIn(misoIn), .mosiSync(mosiSync),
    .rxData(rxData), .serOut(serOut)
  );

  assign sckOut  = sckGen;
  assign sckOe   = isMaster;
  assign mosiOut = serOut;
  assign mosiOe  = isMaster;
  assign misoOut = serOut;
  assign misoOe  = isSlave & ~ssNSync;
  assign hreqOut = ~hreqAsserted;
  assign hreqOe  = isSlave;

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxRead) |=> $stable(rxData)); // R10

endmodule

// File: tb/spi_req_port_bench.sv
module spi_req_port_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;

  logic [7:0]  div = 8'd4;
  logic        mEn = 1'b0, sEn = 1'b0, mSsN = 1'b1, sSsN = 1'b1;
  logic [23:0] mTx = '0, sTx = '0;
  logic        mLoad = 1'b0, sLoad = 1'b0, mRead = 1'b0, sRead = 1'b0;

  logic [23:0] mRx, sRx;
  logic mFull, sFull, mOvr, sOvr, mErr, sErr;
  logic mSck, mSckOe, mMosi, mMosiOe, mMiso, mMisoOe, mHreq, mHreqOe;
  logic sSck, sSckOe, sMosi, sMosiOe, sMiso, sMisoOe, sHreq, sHreqOe;
  logic sckNet, mosiNet, misoNet, hreqNet;

  assign sckNet  = mSckOe ? mSck : 1'b0;
  assign mosiNet = mMosiOe ? mMosi : 1'b0;
  assign misoNet = sMisoOe ? sMiso : 1'b1;
  assign hreqNet = sHreqOe ? sHreq : 1'b1;

  spi_req_port u_spi_req_port (
    .clk(clk), .rstN(rstN), .cfgEnable(mEn), .cfgMaster(1'b1), .clkDiv(div),
    .txData(mTx), .txLoad(mLoad), .rxData(mRx), .rxRead(mRead),
    .rxFull(mFull), .rxOverrun(mOvr), .busError(mErr),
    .sckIn(sckNet), .sckOut(mSck), .sckOe(mSckOe),
    .mosiIn(mosiNet), .mosiOut(mMosi), .mosiOe(mMosiOe),
    .misoIn(misoNet), .misoOut(mMiso), .misoOe(mMisoOe),
    .ssN(mSsN), .hreqIn(hreqNet), .hreqOut(mHreq), .hreqOe(mHreqOe)
  );

  spi_req_port u_peer (
    .clk(clk), .rstN(rstN), .cfgEnable(sEn), .cfgMaster(1'b0), .clkDiv(div),
    .txData(sTx), .txLoad(sLoad), .rxData(sRx), .rxRead(sRead),
    .rxFull(sFull), .rxOverrun(sOvr), .busError(sErr),
    .sckIn(sckNet), .sckOut(sSck), .sckOe(sSckOe),
    .mosiIn(mosiNet), .mosiOut(sMosi), .mosiOe(sMosiOe),
    .misoIn(misoNet), .misoOut(sMiso), .misoOe(sMisoOe),
    .ssN(sSsN), .hreqIn(hreqNet), .hreqOut(sHreq), .hreqOe(sHreqOe)
  );

  // wire monitor: bits seen on rising SCK, rise spacing, rise count
  logic [23:0] monShift = '0;
  int cyc = 0, lastRise = 0, lastGap = 0, riseTotal = 0;
  logic prevSck = 1'b0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (sckNet && !prevSck) begin
      monShift = {monShift[22:0], mosiNet};
      lastGap = cyc - lastRise;
      lastRise = cyc;
      riseTotal = riseTotal + 1;
    end
    prevSck = sckNet;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadM(input logic [23:0] d);
    @(negedge clk); mTx = d; mLoad = 1'b1;
    @(negedge clk); mLoad = 1'b0;
  endtask

  task automatic loadS(input logic [23:0] d);
    @(negedge clk); sTx = d; sLoad = 1'b1;
    @(negedge clk); sLoad = 1'b0;
  endtask

  task automatic readM();
    @(negedge clk); mRead = 1'b1;
    @(negedge clk); mRead = 1'b0;
  endtask

  task automatic readS();
    @(negedge clk); sRead = 1'b1;
    @(negedge clk); sRead = 1'b0;
  endtask

  task automatic waitBoth();
    for (int t = 0; t < 5000 && !(mFull && sFull); t++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic doWord(input logic [23:0] a, input logic [23:0] b);
    loadM(a);
    loadS(b);
    waitBoth();
    tick(2);
    chk("R3", "controller received", mRx, b);
    chk("R3", "target received", sRx, a);
    chk("R3", "MSB-first wire order", monShift, a);
    chk("R4", "rise spacing", lastGap, 2 * (div + 1));
    chk("R9", "both full", {mFull, sFull}, 2'b11);
    chk("R10", "no overrun", {mOvr, sOvr}, 2'b00);
    readM();
    readS();
    tick(1);
    chk("R9", "read clears full", {mFull, sFull}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int rises;
    logic [23:0] a, b;
    tick(5);
    rstN = 1'b1;
    tick(3);
    chk("R1", "enables after reset",
        {mSckOe, mMosiOe, mMisoOe, mHreqOe, sSckOe, sMosiOe, sMisoOe, sHreqOe}, 8'h00);
    chk("R1", "request idle high", sHreq, 1'b1);

    div = 8'd4; mEn = 1'b1; sEn = 1'b1; sSsN = 1'b0;
    tick(4);
    chk("R2", "controller enables", {mSckOe, mMosiOe, mMisoOe, mHreqOe}, 4'b1100);
    chk("R2", "target enables", {sSckOe, sMosiOe, sMisoOe, sHreqOe}, 4'b0011);
    chk("R6", "no request without data", sHreq, 1'b1);

    // controller waits for the request
    loadM(24'hC0FFEE);
    tick(60);
    chk("R5", "no clock without request", riseTotal, 0);
    chk("R5", "clock idles low", mSck, 1'b0);

    loadS(24'h5A17B3);
    tick(3);
    chk("R6", "request asserted", sHreq, 1'b0);
    for (int t = 0; t < 200 && riseTotal == 0; t++) @(negedge clk);
    chk("R6", "request held until pulse seen", sHreq, 1'b0);
    tick(6);
    chk("R6", "request released after first pulse", sHreq, 1'b1);
    waitBoth();
    tick(2);
    chk("R3", "first word controller", mRx, 24'h5A17B3);
    chk("R3", "first word target", sRx, 24'hC0FFEE);
    readM();
    readS();

    // divider and pattern sweep
    for (int d = 4; d <= 7; d++) begin
      div = 8'(d);
      for (int p = 0; p < 4; p++) begin
        a = 24'((p + 1) * 32'h00C35A17 * (d + 3));
        b = ~a ^ 24'(p * 32'h00111111);
        if (p == 3) begin a = 24'hFFFFFF; b = 24'h000001; end
        doWord(a, b);
      end
    end

    // target holds request until read and reload; controller overrun
    div = 8'd5;
    loadM(24'h123456);
    loadS(24'hABCDEF);
    waitBoth();
    tick(2);
    loadS(24'h0F1E2D);
    loadM(24'h778899);
    rises = riseTotal;
    tick(20);
    chk("R6", "request waits for read", sHreq, 1'b1);
    chk("R5", "controller waits while request high", riseTotal, rises);
    readS();
    tick(3);
    chk("R6", "request after read and reload", sHreq, 1'b0);
    for (int t = 0; t < 5000 && !sFull; t++) @(negedge clk);
    tick(30);
    chk("R10", "overrun flagged", mOvr, 1'b1);
    chk("R10", "older word kept", mRx, 24'hABCDEF);
    chk("R9", "target got new word", sRx, 24'h778899);
    readM();
    tick(1);
    chk("R10", "read clears overrun", {mOvr, mFull}, 2'b00);
    readS();

    // deselected target ignores the clock
    sSsN = 1'b1;
    tick(4);
    chk("R7", "data line released", sMisoOe, 1'b0);
    loadS(24'h314159);
    loadM(24'h271828);
    for (int t = 0; t < 5000 && !mFull; t++) @(negedge clk);
    tick(10);
    chk("R7", "controller sees pull-up", mRx, 24'hFFFFFF);
    chk("R7", "target received nothing", sFull, 1'b0);
    chk("R7", "request unchanged", sHreq, 1'b0);
    readM();
    sSsN = 1'b0;
    tick(4);
    chk("R2", "data line driven again", sMisoOe, 1'b1);

    // select low in controller mode
    mSsN = 1'b0;
    tick(4);
    chk("R8", "bus error set", mErr, 1'b1);
    mSsN = 1'b1;
    tick(4);
    chk("R8", "bus error sticky", mErr, 1'b1);
    mEn = 1'b0;
    tick(2);
    chk("R8", "disable clears bus error", mErr, 1'b0);
    chk("R1", "disabled enables", {mSckOe, mMosiOe, mMisoOe, mHreqOe}, 4'b0000);

    summary();
  end

endmodule